// File: doc/BRIEF.md
# Snooping Update Coherence Controller

This block keeps the coherence state of every line of one write-back, write-allocate cache that sits on a shared snooping bus. The protocol is update-based. When another cache writes a shared line, the new data is broadcast and the local copy is refreshed rather than thrown away. Each line is in one of four states: not present (NIC), clean and exclusive (CE), clean and shared (CS), or dirty and exclusive (DE).

On the processor side the controller takes single-cycle read and write requests. A request either completes at once or starts an own bus transaction. That transaction is a read (BR), an update broadcast (BU) or a read that also broadcasts an update (BRU). The transaction lasts two cycles, an address cycle and a response cycle. In the response cycle the wired-OR shared line from the other caches is sampled, and that sample chooses the new state.

On the snoop side the controller takes the address cycle of another cache's transaction. In the following cycle it presents its reactions as single-cycle pulses: drive the shared line, update the local copy, supply the line, or flag an illegal combination. The external bus logic ORs this cache's shared-line output with those of the other caches.

Top module: `coh_update_ctrl`

## Requirements
- R1: After reset every line is NIC and every output is low. The state code is NIC=0, CE=1, CS=2, DE=3.
- R2: A read request to a NIC line starts an own transaction with bus_op=1 (BR). The line becomes CS if shr_in is 1 in the response cycle, and CE otherwise.
- R3: A write request to a NIC line starts an own transaction with bus_op=3 (BRU). The line becomes CS if shr_in is 1, and DE otherwise.
- R4: A read request to a present line starts no transaction and leaves the state unchanged. done pulses one cycle after the request edge and carries that state.
- R5: A write request to a CE or DE line starts no transaction. The line becomes DE, and done pulses one cycle after the request edge.
- R6: A write request to a CS line starts an own transaction with bus_op=2 (BU). The line stays CS if shr_in is 1 in the response cycle, and becomes CE otherwise.
- R7: A snooped BR (snp_op=1) moves CE and CS to CS and drives the shared line. From DE it also supplies the line, and then moves to CS.
- R8: A snooped BU (snp_op=2) keeps a CS line in CS, drives the shared line and updates the copy. In CE or DE the combination is illegal: only snp_err pulses, and the state is unchanged.
- R9: A snooped BRU (snp_op=3) moves CE and CS to CS, updating the copy and driving the shared line. From DE it also supplies the line.
- R10: A snoop that finds the line NIC produces no action and the line stays NIC.
- R11: Snoop actions and snp_state appear in the cycle after the snoop edge and last one cycle. bus_valid stays high for exactly two cycles. The done pulse of a bus-based request comes at the edge that ends the response cycle, so three edges after the request edge.
- R12: A request presented while busy is high, or in the same cycle as snp_valid, is ignored.
- R13: A request or snoop changes only the line it indexes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Single-cycle processor request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | IDX_W | Line index of the request |
| done | output | 1 | Request completion pulse |
| done_state | output | 2 | Line state after the completed request |
| busy | output | 1 | Own transaction in progress |
| bus_valid | output | 1 | Own bus transaction active (address and response cycles) |
| bus_op | output | 2 | Own transaction kind: 1 BR, 2 BU, 3 BRU |
| bus_index | output | IDX_W | Line index of the own transaction |
| shr_in | input | 1 | Wired-OR shared line from the other caches |
| snp_valid | input | 1 | Address cycle of a remote transaction |
| snp_op | input | 2 | Remote transaction kind: 1 BR, 2 BU, 3 BRU |
| snp_index | input | IDX_W | Line index of the remote transaction |
| shr_out | output | 1 | This cache drives the shared line |
| snp_upd | output | 1 | Update local copy with broadcast data |
| snp_prov | output | 1 | Supply the line (memory is updated alongside) |
| snp_err | output | 1 | Illegal snoop and state combination |
| snp_state | output | 2 | Line state after the last snoop |

## Verification
A request that hits produces done one edge after its request edge. A request that needs the bus raises bus_valid after the request edge, keeps it high for two cycles, and produces done after the third edge. The bench counts edges at every falling edge and checks both the latency and the number of bus_valid cycles. Snoop reactions are sampled at the falling edge after the snoop edge and again one cycle later, which confirms that each is a one-cycle pulse. Every start state is reached through the processor interface, each state and stimulus pair is swept, and the final state is then read back with a read request on the same line and a neighbouring line.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_NIC = 2'd0,
    ST_CE  = 2'd1,
    ST_CS  = 2'd2,
    ST_DE  = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RD    = 2'd1,
    OP_UPD   = 2'd2,
    OP_RDUPD = 2'd3
  } bus_op_e;

  typedef struct packed {
    logic     shr;
    logic     upd;
    logic     prov;
    logic     err;
    logic     wr_en;
    line_st_e nxt;
  } snp_resp_t;

  // state after an own fill transaction, chosen by the sampled shared line
  function automatic line_st_e fill_state(input logic is_write, input logic shared);
    if (shared)        return ST_CS;
    else if (is_write) return ST_DE;
    else               return ST_CE;
  endfunction

  // state after an own update broadcast
  function automatic line_st_e bcast_state(input logic shared);
    return shared ? ST_CS : ST_CE;
  endfunction

endpackage

// File: rtl/coh_state_store.sv
module coh_state_store
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_a_idx,
  output line_st_e         rd_a_st,
  input  logic [IDX_W-1:0] rd_b_idx,
  output line_st_e         rd_b_st,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_e         wr_st
);

  line_st_e st_q [LINES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (rst)
        st_q[i] <= ST_NIC;
      else if (we && wr_idx == IDX_W'(i))
        st_q[i] <= wr_st;
    end
  end

  assign rd_a_st = st_q[rd_a_idx];
  assign rd_b_st = st_q[rd_b_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
(
  input  bus_op_e   op,
  input  line_st_e  cur,
  output snp_resp_t rsp
);

  always_comb begin
    rsp     = '0;
    rsp.nxt = cur;
    unique case (op)
      OP_RD: begin
        if (cur != ST_NIC) begin
          rsp.shr   = 1'b1;
          rsp.prov  = (cur == ST_DE);
          rsp.nxt   = ST_CS;
          rsp.wr_en = 1'b1;
        end
      end
      OP_UPD: begin
        if (cur == ST_CS) begin
          rsp.shr = 1'b1;
          rsp.upd = 1'b1;
        end else if (cur != ST_NIC) begin
          rsp.err = 1'b1;
        end
      end
      OP_RDUPD: begin
        if (cur != ST_NIC) begin
          rsp.shr   = 1'b1;
          rsp.upd   = 1'b1;
          rsp.prov  = (cur == ST_DE);
          rsp.nxt   = ST_CS;
          rsp.wr_en = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/coh_proc_unit.sv
module coh_proc_unit
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_index,
  input  logic             blocked,
  input  line_st_e         cur_st,
  input  logic             shr_in,
  output logic [IDX_W-1:0] look_idx,
  output logic             bus_valid,
  output bus_op_e          bus_op,
  output logic [IDX_W-1:0] bus_index,
  output logic             done,
  output line_st_e         done_state,
  output logic             busy,
  output logic             we,
  output logic [IDX_W-1:0] wr_idx,
  output line_st_e         wr_st
);

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_RESP} phase_e;

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  bus_op_e          op_q;
  logic             bus_v_q;
  logic             done_q;
  line_st_e         done_st_q;

  logic     accept;
  logic     need_bus;
  bus_op_e  op_sel;
  line_st_e hit_next;
  line_st_e resp_next;

  assign accept    = req_valid && (phase_q == PH_IDLE) && !blocked;
  assign need_bus  = (cur_st == ST_NIC) || (req_write && cur_st == ST_CS);
  assign op_sel    = (cur_st == ST_NIC) ? (req_write ? OP_RDUPD : OP_RD) : OP_UPD;
  assign hit_next  = req_write ? ST_DE : cur_st;
  assign resp_next = (op_q == OP_UPD) ? bcast_state(shr_in)
                                      : fill_state(op_q == OP_RDUPD, shr_in);

  assign look_idx  = (phase_q == PH_IDLE) ? req_index : idx_q;
  assign we        = (accept && !need_bus && req_write) || (phase_q == PH_RESP);
  assign wr_idx    = (phase_q == PH_RESP) ? idx_q : req_index;
  assign wr_st     = (phase_q == PH_RESP) ? resp_next : hit_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      idx_q     <= '0;
      op_q      <= OP_NONE;
      bus_v_q   <= 1'b0;
      done_q    <= 1'b0;
      done_st_q <= ST_NIC;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            if (need_bus) begin
              phase_q <= PH_ADDR;
              idx_q   <= req_index;
              op_q    <= op_sel;
              bus_v_q <= 1'b1;
            end else begin
              done_q    <= 1'b1;
              done_st_q <= hit_next;
            end
          end
        end
        PH_ADDR: phase_q <= PH_RESP;
        PH_RESP: begin
          phase_q   <= PH_IDLE;
          op_q      <= OP_NONE;
          bus_v_q   <= 1'b0;
          done_q    <= 1'b1;
          done_st_q <= resp_next;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign bus_valid  = bus_v_q;
  assign bus_op     = op_q;
  assign bus_index  = idx_q;
  assign done       = done_q;
  assign done_state = done_st_q;
  assign busy       = (phase_q != PH_IDLE);

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) |=> bus_valid); // R11
  AST_BUS_END: assert property (@(posedge clk) disable iff (rst)
    bus_valid && $past(bus_valid) |=> !bus_valid && done); // R11
  AST_BU_ONLY_CS: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) && bus_op == OP_UPD |-> $past(cur_st) == ST_CS); // R6
  AST_HIT_PRESENT: assert property (@(posedge clk) disable iff (rst)
    done && !$past(bus_valid) |-> $past(cur_st) != ST_NIC); // R4

endmodule

// File: rtl/coh_update_ctrl.sv
module coh_update_ctrl
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_index,
  output logic             done,
  output logic [1:0]       done_state,
  output logic             busy,
  output logic             bus_valid,
  output logic [1:0]       bus_op,
  output logic [IDX_W-1:0] bus_index,
  input  logic             shr_in,
  input  logic             snp_valid,
  input  logic [1:0]       snp_op,
  input  logic [IDX_W-1:0] snp_index,
  output logic             shr_out,
  output logic             snp_upd,
  output logic             snp_prov,
  output logic             snp_err,
  output logic [1:0]       snp_state
);

  line_st_e         proc_cur;
  line_st_e         snp_cur;
  logic [IDX_W-1:0] look_idx;
  logic             p_we;
  logic [IDX_W-1:0] p_wr_idx;
  line_st_e         p_wr_st;
  snp_resp_t        srsp;
  logic             s_we;
  logic             st_we;
  logic [IDX_W-1:0] st_wr_idx;
  line_st_e         st_wr_st;
  bus_op_e          p_bus_op;
  line_st_e         p_done_st;

  logic     shr_q, upd_q, prov_q, err_q;
  line_st_e sst_q;

  coh_snoop_unit u_snoop (
    .op  (bus_op_e'(snp_op)),
    .cur (snp_cur),
    .rsp (srsp)
  );

  assign s_we      = snp_valid && srsp.wr_en;
  assign st_we     = s_we || p_we;
  assign st_wr_idx = s_we ? snp_index : p_wr_idx;
  assign st_wr_st  = s_we ? srsp.nxt  : p_wr_st;

  coh_state_store #(.LINES(LINES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (look_idx),
    .rd_a_st  (proc_cur),
    .rd_b_idx (snp_index),
    .rd_b_st  (snp_cur),
    .we       (st_we),
    .wr_idx   (st_wr_idx),
    .wr_st    (st_wr_st)
  );

  coh_proc_unit #(.LINES(LINES)) u_proc (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_index  (req_index),
    .blocked    (snp_valid),
    .cur_st     (proc_cur),
    .shr_in     (shr_in),
    .look_idx   (look_idx),
    .bus_valid  (bus_valid),
    .bus_op     (p_bus_op),
    .bus_index  (bus_index),
    .done       (done),
    .done_state (p_done_st),
    .busy       (busy),
    .we         (p_we),
    .wr_idx     (p_wr_idx),
    .wr_st      (p_wr_st)
  );

  assign bus_op     = p_bus_op;
  assign done_state = p_done_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      shr_q  <= 1'b0;
      upd_q  <= 1'b0;
      prov_q <= 1'b0;
      err_q  <= 1'b0;
      sst_q  <= ST_NIC;
    end else begin
      shr_q  <= snp_valid && srsp.shr;
      upd_q  <= snp_valid && srsp.upd;
      prov_q <= snp_valid && srsp.prov;
      err_q  <= snp_valid && srsp.err;
      if (snp_valid) sst_q <= srsp.nxt;
    end
  end

  assign shr_out   = shr_q;
  assign snp_upd   = upd_q;
  assign snp_prov  = prov_q;
  assign snp_err   = err_q;
  assign snp_state = sst_q;

  AST_NO_SNOOP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !snp_valid); // R12
  AST_PROV_ONLY_DIRTY: assert property (@(posedge clk) disable iff (rst)
    snp_valid && snp_cur != ST_DE |=> !snp_prov); // R7
  AST_ERR_ALONE: assert property (@(posedge clk) disable iff (rst)
    snp_err |-> !shr_out && !snp_upd && !snp_prov); // R8
  AST_NIC_QUIET: assert property (@(posedge clk) disable iff (rst)
    snp_valid && snp_cur == ST_NIC |=> !shr_out && !snp_upd && !snp_prov && !snp_err); // R10

endmodule

// File: tb/coh_update_ctrl_test.sv
`timescale 1ns/1ps
module coh_update_ctrl_test;

  localparam int LINES = 16;
  localparam int IDX_W = $clog2(LINES);

  logic             clk = 1'b0;
  logic             rst;
  logic             req_valid, req_write;
  logic [IDX_W-1:0] req_index;
  logic             done, busy, bus_valid;
  logic [1:0]       done_state, bus_op;
  logic [IDX_W-1:0] bus_index;
  logic             shr_in, snp_valid;
  logic [1:0]       snp_op;
  logic [IDX_W-1:0] snp_index;
  logic             shr_out, snp_upd, snp_prov, snp_err;
  logic [1:0]       snp_state;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  coh_update_ctrl #(.LINES(LINES)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_index(req_index),
    .done(done), .done_state(done_state), .busy(busy),
    .bus_valid(bus_valid), .bus_op(bus_op), .bus_index(bus_index),
    .shr_in(shr_in),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_index(snp_index),
    .shr_out(shr_out), .snp_upd(snp_upd), .snp_prov(snp_prov),
    .snp_err(snp_err), .snp_state(snp_state)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_index = '0;
    shr_in = 1'b0; snp_valid = 1'b0; snp_op = 2'd0; snp_index = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // issue one request at a falling edge, count edges until done
  task automatic proc_op(input int idx, input logic wr, input logic shr,
                         output int lat, output int st, output int op, output int bcnt);
    req_index = IDX_W'(idx); req_write = wr; shr_in = shr; req_valid = 1'b1;
    lat = 0; st = 0; op = 0; bcnt = 0;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (bus_valid) begin bcnt++; op = int'(bus_op); end
      if (done) begin lat = k; st = int'(done_state); break; end
    end
    shr_in = 1'b0;
  endtask

  // expected outcome of a request: hit takes 1 edge, bus request 3 edges
  task automatic exp_proc(input int s, input logic wr, input logic shr,
                          output int lat, output int op, output int st, output string tag);
    if (s == 0) begin
      lat = 3; op = wr ? 3 : 1;
      st  = shr ? 2 : (wr ? 3 : 1);
      tag = wr ? "R3" : "R2";
    end else if (!wr) begin
      lat = 1; op = 0; st = s; tag = "R4";
    end else if (s == 2) begin
      lat = 3; op = 2; st = shr ? 2 : 1; tag = "R6";
    end else begin
      lat = 1; op = 0; st = 3; tag = "R5";
    end
  endtask

  task automatic exp_snp(input int s, input int op,
                         output int shr, output int upd, output int prov,
                         output int err, output int nst, output string tag);
    shr = 0; upd = 0; prov = 0; err = 0; nst = s;
    tag = (op == 1) ? "R7" : (op == 2) ? "R8" : "R9";
    if (s == 0) tag = "R10";
    else if (op == 1) begin shr = 1; prov = (s == 3); nst = 2; end
    else if (op == 2) begin
      if (s == 2) begin shr = 1; upd = 1; end else err = 1;
    end else begin shr = 1; upd = 1; prov = (s == 3); nst = 2; end
  endtask

  task automatic reach(input int s);
    int l, t, o, b;
    if (s == 1) proc_op(5, 1'b0, 1'b0, l, t, o, b);
    if (s == 2) proc_op(5, 1'b0, 1'b1, l, t, o, b);
    if (s == 3) proc_op(5, 1'b1, 1'b0, l, t, o, b);
  endtask

  // read back a line through the request port
  task automatic probe(input int idx, input int exp_st, input string tag);
    int l, t, o, b;
    proc_op(idx, 1'b0, 1'b0, l, t, o, b);
    if (exp_st == 0) begin
      chk(tag, "probe absent: latency", l, 3);
      chk(tag, "probe absent: bus_op", o, 1);
    end else begin
      chk(tag, "probe present: latency", l, 1);
      chk(tag, "probe present: state", t, exp_st);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R11 act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int l, t, o, b;
    int el, eo, et;
    int es, eu, ep, ee, en;
    string tag;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_index = '0;
    shr_in = 1'b0; snp_valid = 1'b0; snp_op = 2'd0; snp_index = '0;

    // R1: reset state
    do_reset();
    chk("R1", "done", int'(done), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "bus_valid", int'(bus_valid), 0);
    chk("R1", "snoop outputs", int'({shr_out, snp_upd, snp_prov, snp_err}), 0);
    chk("R1", "snp_state", int'(snp_state), 0);
    probe(3, 0, "R1");

    // sweep every start state against every stimulus
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 7; c++) begin
        do_reset();
        reach(s);
        if (c < 4) begin
          exp_proc(s, c[1], c[0], el, eo, et, tag);
          proc_op(5, c[1], c[0], l, t, o, b);
          chk(tag, "latency", l, el);
          chk(tag, "bus_op", o, eo);
          chk("R11", "bus_valid cycles", b, (el == 3) ? 2 : 0);
          chk(tag, "done_state", t, et);
        end else begin
          exp_snp(s, c - 3, es, eu, ep, ee, en, tag);
          snp_index = IDX_W'(5); snp_op = 2'(c - 3); snp_valid = 1'b1;
          @(posedge clk);
          @(negedge clk);
          snp_valid = 1'b0;
          chk(tag, "shr_out", int'(shr_out), es);
          chk(tag, "snp_upd", int'(snp_upd), eu);
          chk(tag, "snp_prov", int'(snp_prov), ep);
          chk(tag, "snp_err", int'(snp_err), ee);
          chk(tag, "snp_state", int'(snp_state), en);
          @(posedge clk);
          @(negedge clk);
          chk("R11", "snoop pulse cleared",
              int'({shr_out, snp_upd, snp_prov, snp_err}), 0);
          et = en;
        end
        probe(5, et, tag);
        probe(6, 0, "R13");
      end
    end

    // R12: request in the same cycle as a snoop is dropped
    do_reset();
    req_index = IDX_W'(7); req_write = 1'b1; req_valid = 1'b1;
    snp_index = IDX_W'(7); snp_op = 2'd1; snp_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; snp_valid = 1'b0;
    chk("R12", "done with snoop", int'(done), 0);
    chk("R12", "bus_valid with snoop", int'(bus_valid), 0);
    chk("R12", "busy with snoop", int'(busy), 0);
    probe(7, 0, "R12");

    // R12: request while busy is dropped
    do_reset();
    req_index = IDX_W'(8); req_write = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R12", "busy after miss", int'(busy), 1);
    chk("R2", "bus_index", int'(bus_index), 8);
    req_index = IDX_W'(9); req_write = 1'b1; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11", "done of miss", int'(done), 1);
    chk("R2", "miss fill state", int'(done_state), 1);
    @(posedge clk);
    @(negedge clk);
    chk("R12", "no second done", int'(done), 0);
    probe(9, 0, "R12");
    probe(8, 1, "R13");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule